// File: doc/BRIEF.md
# Cascaded BCD Decade Counter

A decimal counter built from a chain of four-bit BCD digits, three by default, so it runs from 000 to 999. Every digit steps 0 through 9 and returns to 0. A digit steps only in a cycle where the count enable is high and every digit below it reads 9, so a higher digit moves by one when the digit under it wraps from 9 to 0. All flip-flops share one clock. A carry enable runs up the chain; no digit is clocked from the output of another.

A synchronous load writes a full BCD value into all digits at once and takes priority over counting. With load and enable both low, the value holds. A parameter selects how each digit wraps. In one variant the digit detects 9 and loads zero on the next edge. In the other variant the incremented value is checked for 1010 and replaced by zero before it is stored, so 1010 never reaches a register. A terminal-count output flags the cycle in which an enabled count will roll 999 over to 000. Load values with a digit above 9 are not supported.

Top module: `bcd_chain_counter`

## Requirements
- R1: While rst_ni is low, count_o reads 000 at once, without waiting for a clock edge.
- R2: With load_i high at a rising edge, count_o equals load_val_i after that edge, whatever cnt_en_i is.
- R3: With load_i and cnt_en_i both low at a rising edge, count_o does not change.
- R4: With cnt_en_i high and load_i low, the least significant digit count_o[3:0] advances by one per edge, and goes from 9 to 0.
- R5: A higher digit advances by one at exactly the edges where every lower digit reads 9 and counting is enabled. In every other counting cycle it holds.
- R6: From 999, an enabled count with load_i low gives 000.
- R7: tc_o is high exactly when cnt_en_i is high and every digit of count_o reads 9. It is combinational in the same cycle.
- R8: No digit of count_o ever reads above 9. Both settings of WRAP_MODE (nine-detect load, ten-detect clear) produce the same count sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count enable |
| load_i | input | 1 | Synchronous parallel load, overrides counting |
| load_val_i | input | 12 | BCD value to load, digit 0 in bits 3:0 |
| count_o | output | 12 | BCD count, digit 0 in bits 3:0 |
| tc_o | output | 1 | Terminal count: enabled and all digits 9 |

## Verification
A broken carry term shows up at the next edge as a higher digit that moves too early or stays frozen. The 1000-step sweep compares every count against a decimal model and catches this at the first faulty edge. A wrong wrap value, such as 1010 being stored, shows as an invalid digit or as a skipped 0 within ten enabled cycles. A fault in load priority or in the hold path shows in the count one edge after the stimulus. Both wrap variants are run in lockstep, so a variant that drifts from the other is caught on the step where it drifts.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  typedef logic [3:0] digit_t;
  typedef enum logic {
    WRAP_LOAD9  = 1'b0,
    WRAP_CLEAR10 = 1'b1
  } wrap_mode_e;
endpackage

// File: rtl/bcd_decade.sv
module bcd_decade import bcd_pkg::*; #(
  parameter wrap_mode_e MODE = WRAP_LOAD9
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  logic   load_i,
  input  digit_t load_val_i,
  output digit_t digit_o,
  output logic   carry_o
);
  digit_t q_q, q_d, inc, step_val;

  assign inc = q_q + 4'd1;

  generate
    if (MODE == WRAP_LOAD9) begin : g_load9
      logic at_nine;
      assign at_nine  = (q_q == 4'd9);
      assign step_val = at_nine ? 4'd0 : inc;
      assign carry_o  = en_i & at_nine;
    end else begin : g_clear10
      // 1010 is caught on the incremented value, never stored
      logic at_ten;
      assign at_ten   = (inc == 4'd10);
      assign step_val = at_ten ? 4'd0 : inc;
      assign carry_o  = en_i & at_ten;
    end
  endgenerate

  always_comb begin
    if (load_i)    q_d = load_val_i;
    else if (en_i) q_d = step_val;
    else           q_d = q_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 4'd0;
    else         q_q <= q_d;
  end

  assign digit_o = q_q;

  AST_DIGIT_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_q <= 4'd9); // R8
  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> q_q == $past(load_val_i)); // R2
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !en_i) |=> $stable(q_q)); // R3
  AST_NINE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i && q_q == 4'd9) |=> q_q == 4'd0); // R4
endmodule

// File: rtl/bcd_term_detect.sv
module bcd_term_detect #(
  parameter int NUM_DIGITS = 3,
  localparam int W = 4 * NUM_DIGITS
) (
  input  logic [W-1:0] count_i,
  input  logic         en_i,
  output logic         tc_o
);
  logic [NUM_DIGITS-1:0] is_nine;

  generate
    for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_nine
      assign is_nine[k] = (count_i[4*k +: 4] == 4'd9);
    end
  endgenerate

  assign tc_o = en_i & (&is_nine);
endmodule

// File: rtl/bcd_chain_counter.sv
module bcd_chain_counter import bcd_pkg::*; #(
  parameter int         NUM_DIGITS = 3,
  parameter wrap_mode_e WRAP_MODE  = WRAP_LOAD9,
  localparam int W = 4 * NUM_DIGITS
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cnt_en_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] count_o,
  output logic         tc_o
);
  logic [NUM_DIGITS:0]   en_chain;
  logic [NUM_DIGITS-1:0] carry;

  assign en_chain[0] = cnt_en_i;

  generate
    for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_dec
      bcd_decade #(.MODE(WRAP_MODE)) i_decade (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (en_chain[k]),
        .load_i     (load_i),
        .load_val_i (load_val_i[4*k +: 4]),
        .digit_o    (count_o[4*k +: 4]),
        .carry_o    (carry[k])
      );
      assign en_chain[k+1] = carry[k];
    end
  endgenerate

  bcd_term_detect #(.NUM_DIGITS(NUM_DIGITS)) i_term (
    .count_i (count_o),
    .en_i    (cnt_en_i),
    .tc_o    (tc_o)
  );

  AST_ROLLOVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && !load_i) |=> count_o == '0); // R6
  AST_TC_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> cnt_en_i); // R7
  AST_TENS_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !load_i && count_o[3:0] == 4'd9 && count_o[7:4] != 4'd9)
    |=> count_o[7:4] == $past(count_o[7:4]) + 4'd1); // R5
  AST_TENS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && count_o[3:0] != 4'd9) |=> $stable(count_o[7:4])); // R5
endmodule

// File: tb/test_bcd_chain_counter.sv
module test_bcd_chain_counter;
  import bcd_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        load = 1'b0;
  logic [11:0] load_val = '0;
  logic [11:0] cnt_a, cnt_b;
  logic        tc_a, tc_b;
  int          n_vec = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  bcd_chain_counter #(.WRAP_MODE(WRAP_LOAD9)) i_bcd_chain_counter (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cnt_en), .load_i(load),
    .load_val_i(load_val), .count_o(cnt_a), .tc_o(tc_a));

  bcd_chain_counter #(.WRAP_MODE(WRAP_CLEAR10)) i_bcd_chain_counter_clr (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cnt_en), .load_i(load),
    .load_val_i(load_val), .count_o(cnt_b), .tc_o(tc_b));

  // {load, en, load_val[11:0], exp_count[11:0], exp_tc_before_edge}
  localparam int NV = 15;
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 1'b0, 12'h000, 12'h000, 1'b0}, // R3 hold
    {1'b1, 1'b0, 12'h007, 12'h007, 1'b0}, // R2 load
    {1'b0, 1'b1, 12'h000, 12'h008, 1'b0}, // R4
    {1'b0, 1'b1, 12'h000, 12'h009, 1'b0}, // R4
    {1'b0, 1'b1, 12'h000, 12'h010, 1'b0}, // R5 tens step
    {1'b1, 1'b1, 12'h099, 12'h099, 1'b0}, // R2 load over count
    {1'b0, 1'b1, 12'h000, 12'h100, 1'b0}, // R5 double carry
    {1'b0, 1'b0, 12'h000, 12'h100, 1'b0}, // R3 hold
    {1'b1, 1'b0, 12'h998, 12'h998, 1'b0}, // R2
    {1'b0, 1'b1, 12'h000, 12'h999, 1'b0}, // R4
    {1'b0, 1'b0, 12'h000, 12'h999, 1'b0}, // R7 no tc without enable
    {1'b0, 1'b1, 12'h000, 12'h000, 1'b1}, // R6 rollover, R7
    {1'b1, 1'b0, 12'h999, 12'h999, 1'b0}, // R2
    {1'b1, 1'b1, 12'h123, 12'h123, 1'b1}, // R2 load beats rollover, R7
    {1'b0, 1'b1, 12'h000, 12'h124, 1'b0}  // R4
  };

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] to_bcd(input int n);
    return {4'(n / 100), 4'((n / 10) % 10), 4'(n % 10)};
  endfunction

  function automatic bit digits_ok(input logic [11:0] v);
    return v[3:0] <= 4'd9 && v[7:4] <= 4'd9 && v[11:8] <= 4'd9;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    #15;
    chk("R1 reset", cnt_a, 12'h000);
    chk("R1 reset clr", cnt_b, 12'h000);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      load     = VEC[i][26];
      cnt_en   = VEC[i][25];
      load_val = VEC[i][24:13];
      #1;
      chk("R7 tc", {11'd0, tc_a}, {11'd0, VEC[i][0]});
      chk("R7 tc clr", {11'd0, tc_b}, {11'd0, VEC[i][0]});
      @(negedge clk);
      chk("R2-R6 count", cnt_a, VEC[i][12:1]);
      chk("R8 count clr", cnt_b, VEC[i][12:1]);
      load = 1'b0; cnt_en = 1'b0;
    end

    // full sweep from 000 through rollover
    @(negedge clk);
    load = 1'b1; load_val = 12'h000;
    @(negedge clk);
    load = 1'b0; cnt_en = 1'b1;
    for (int n = 0; n < 1002; n++) begin
      #1;
      chk("R7 tc sweep", {11'd0, tc_a}, {11'd0, (n % 1000) == 999});
      @(negedge clk);
      chk("R5 sweep", cnt_a, to_bcd((n + 1) % 1000));
      chk("R8 sweep clr", cnt_b, to_bcd((n + 1) % 1000));
      chk("R8 digits", {11'd0, digits_ok(cnt_a) && digits_ok(cnt_b)}, 12'd1);
    end
    cnt_en = 1'b0;

    // asynchronous reset mid-count
    @(negedge clk);
    load = 1'b1; load_val = 12'h456;
    @(negedge clk);
    load = 1'b0;
    chk("R2 preload", cnt_a, 12'h456);
    #5 rst_n = 1'b0;
    #1;
    chk("R1 async", cnt_a, 12'h000);
    chk("R1 async clr", cnt_b, 12'h000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule